// File: doc/BRIEF.md
# Write-Only Display Link Receiver

This block is the two-wire serial front end of a character display controller. It watches raw SCL and SDA lines with a faster system clock, recognises bus START and STOP conditions, and answers only to one fixed 7-bit address when the direction bit requests a write. Once it has been addressed, it acknowledges every byte by pulling SDA low through the ninth clock of that byte. SDA is driven as an open-drain pull-low enable. The block never returns data to the bus.

After the address, the incoming bytes are treated as a framed stream. A control byte carries two flags: a continuation flag in bit 7 and a register-select flag in bit 6. While the continuation flag is set, each control byte is followed by exactly one payload byte. When a control byte has the continuation flag clear, every later byte up to STOP is a payload byte, and all of them use that control byte's select. Each payload byte appears on the output for a single system clock cycle, together with its select flag. The flag reads 1 for RAM data and 0 for an instruction, and the display core behind this block uses it to route the byte.

Top module: `dispwr_i2c_rx`

## Requirements
- R1: After reset, the SDA pull-down enable and the payload valid output are both 0.
- R2: A byte of 0x7C after START (address 0111110 followed by direction bit 0) is acknowledged: the SDA pull-down is asserted through the high phase of the ninth SCL pulse.
- R3: When the address byte is not 0111110, the block gives no acknowledge, emits no payload, and acknowledges none of the bytes that follow until the next START.
- R4: An address byte of 0x7D (the matching address with direction bit 1, a read) gets no acknowledge and produces no payload.
- R5: Once the block has been addressed, every control byte and every payload byte is acknowledged.
- R6: While a control byte has bit 7 = 1, exactly one payload byte follows it, and then a new control byte is expected. Control bytes never appear on the payload output.
- R7: After a control byte with bit 7 = 0, every byte up to STOP or a repeated START is emitted as payload with that control byte's select.
- R8: The payload select output equals bit 6 of the governing control byte: 1 means RAM data, 0 means instruction. The payload value is the byte exactly as received, MSB first.
- R9: A repeated START puts the block back into the address phase. The next byte is matched as an address, and the byte after that is a control byte.
- R10: The SDA pull-down is released within a few system clocks after the SCL falling edge that ends the acknowledge bit, before the next data bit's high phase.
- R11: Each payload byte is signalled by a valid pulse exactly one system clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (resolved bus level) |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| pl_valid_o | output | 1 | One-cycle strobe for a payload byte |
| pl_byte_o | output | 8 | Payload byte value |
| pl_is_data_o | output | 1 | 1 = RAM data, 0 = instruction |

## Verification
The bench targets the framing boundaries. A control byte whose continuation flag is clear must switch the stream to payload-only; a design that misses this would take the third and later bytes as control bytes and drop them. A repeated START must send the next byte back through address matching; without that, the address byte would leak out as payload. A mismatched address and a read request must both leave SDA untouched: a design that still acknowledged them would hold the bus low for another device's transfer. The bench also checks that the pull-down is released just after the acknowledge clock, because a late release would corrupt the master's next MSB.

// File: rtl/dispwr_pkg.sv
package dispwr_pkg;
  // link-level phase of the receiver
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_BYTES = 2'd2,
    PH_SKIP  = 2'd3
  } link_ph_t;

  // framing of the byte stream after addressing
  typedef enum logic [1:0] {
    FR_CTRL = 2'd0,
    FR_ONE  = 2'd1,
    FR_ALL  = 2'd2
  } frame_t;
endpackage

// File: rtl/dispwr_line_sync.sv
module dispwr_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic q;
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= RST_VAL;
          else     q <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= RST_VAL;
          else     q <= g_stg[i-1].q;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= g_stg[STAGES-1].q;
  end

  assign lvl_o  = g_stg[STAGES-1].q;
  assign rise_o = g_stg[STAGES-1].q & ~prev_q;
  assign fall_o = ~g_stg[STAGES-1].q & prev_q;
endmodule

// File: rtl/dispwr_link.sv
module dispwr_link
  import dispwr_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter logic [6:0]  DEV_ADR = 7'b0111110,
  parameter int          BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              sda_pull,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic              frame_rst
);
  localparam int CNT_W    = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] ADR_WR = {DEV_ADR[ADDR_W-1:0], {(BYTE_W-ADDR_W){1'b0}}};

  link_ph_t          ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              start_c, stop_c, active_c;

  assign start_c  = sda_fall & scl_lvl;
  assign stop_c   = sda_rise & scl_lvl;
  assign active_c = (ph_q == PH_ADDR) || (ph_q == PH_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      sda_pull  <= 1'b0;
      byte_stb  <= 1'b0;
      byte_val  <= '0;
      frame_rst <= 1'b0;
    end else begin
      byte_stb  <= 1'b0;
      frame_rst <= 1'b0;
      if (start_c) begin
        ph_q     <= PH_ADDR;
        cnt_q    <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        ph_q     <= PH_IDLE;
        cnt_q    <= '0;
        sda_pull <= 1'b0;
      end else if (active_c) begin
        if (scl_rise && (cnt_q < LAST_BIT)) begin
          sr_q  <= {sr_q[BYTE_W-2:0], sda_lvl};
          cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall && (cnt_q == LAST_BIT)) begin
          cnt_q <= ACK_SLOT;
          if (ph_q == PH_ADDR) begin
            if (sr_q == ADR_WR) begin
              sda_pull  <= 1'b1;
              frame_rst <= 1'b1;
              ph_q      <= PH_BYTES;
            end else begin
              ph_q <= PH_SKIP;
            end
          end else begin
            sda_pull <= 1'b1;
            byte_stb <= 1'b1;
            byte_val <= sr_q;
          end
        end else if (scl_fall && (cnt_q == ACK_SLOT)) begin
          sda_pull <= 1'b0;
          cnt_q    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dispwr_frame.sv
module dispwr_frame
  import dispwr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_rst,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              pl_valid,
  output logic [BYTE_W-1:0] pl_byte,
  output logic              pl_sel
);
  localparam int CO_BIT = BYTE_W - 1;
  localparam int RS_BIT = BYTE_W - 2;

  frame_t fr_q;
  logic   sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_q     <= FR_CTRL;
      sel_q    <= 1'b0;
      pl_valid <= 1'b0;
      pl_byte  <= '0;
      pl_sel   <= 1'b0;
    end else begin
      pl_valid <= 1'b0;
      if (frame_rst) begin
        fr_q <= FR_CTRL;
      end else if (byte_stb) begin
        case (fr_q)
          FR_CTRL: begin
            sel_q <= byte_val[RS_BIT];
            fr_q  <= byte_val[CO_BIT] ? FR_ONE : FR_ALL;
          end
          FR_ONE: begin
            pl_valid <= 1'b1;
            pl_byte  <= byte_val;
            pl_sel   <= sel_q;
            fr_q     <= FR_CTRL;
          end
          default: begin
            pl_valid <= 1'b1;
            pl_byte  <= byte_val;
            pl_sel   <= sel_q;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dispwr_i2c_rx.sv
module dispwr_i2c_rx #(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 7,
  parameter logic [6:0] DEV_ADR     = 7'b0111110,
  parameter int         BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              pl_valid_o,
  output logic [BYTE_W-1:0] pl_byte_o,
  output logic              pl_is_data_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic byte_stb, frame_rst;
  logic [BYTE_W-1:0] byte_val;

  dispwr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  dispwr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  dispwr_link #(.ADDR_W(ADDR_W), .DEV_ADR(DEV_ADR), .BYTE_W(BYTE_W)) u_link (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .sda_pull(sda_pull_o), .byte_stb(byte_stb), .byte_val(byte_val),
    .frame_rst(frame_rst)
  );

  dispwr_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst(rst),
    .frame_rst(frame_rst), .byte_stb(byte_stb), .byte_val(byte_val),
    .pl_valid(pl_valid_o), .pl_byte(pl_byte_o), .pl_sel(pl_is_data_o)
  );
endmodule

// File: rtl/dispwr_i2c_rx_chk.sv
module dispwr_i2c_rx_chk (
  input logic clk,
  input logic rst,
  input logic sda_pull_o,
  input logic pl_valid_o,
  input logic scl_lvl,
  input logic scl_fall,
  input logic sda_rise,
  input logic sda_fall,
  input logic byte_stb
);
  // R11: payload strobe lasts one cycle
  a_r11_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pl_valid_o |=> !pl_valid_o);

  // R2/R5: acknowledge is launched only on an SCL falling edge
  a_r5_pull_on_scl_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> $past(scl_fall));

  // R10: release follows an SCL fall, or a START/STOP seen while SCL high
  a_r10_release_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull_o) |-> ($past(scl_fall) || ($past(scl_lvl) && ($past(sda_rise) || $past(sda_fall)))));

  // R2: SDA drive stays stable while SCL is high
  a_r2_pull_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && $past(scl_lvl) && !sda_rise && !sda_fall) |-> $stable(sda_pull_o));

  // R8: every payload strobe comes from a received byte one cycle before
  a_r8_valid_from_byte: assert property (@(posedge clk) disable iff (rst)
    pl_valid_o |-> $past(byte_stb));
endmodule

bind dispwr_i2c_rx dispwr_i2c_rx_chk u_chk (
  .clk(clk), .rst(rst), .sda_pull_o(sda_pull_o), .pl_valid_o(pl_valid_o),
  .scl_lvl(scl_lvl), .scl_fall(scl_fall), .sda_rise(sda_rise),
  .sda_fall(sda_fall), .byte_stb(byte_stb)
);

// File: tb/dispwr_i2c_rx_test.sv
module dispwr_i2c_rx_test;
  localparam int HALF = 10;
  localparam int NV   = 6;
  // {control byte, data byte}; expected select = control bit 6
  localparam logic [15:0] VECS [0:NV-1] = '{
    16'h80_3A, 16'hC0_41, 16'h00_01, 16'h40_7E, 16'hBF_A5, 16'h7F_FF
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, pl_valid, pl_is_data;
  logic [7:0] pl_byte;
  logic bus_sda;
  int checks = 0, fails = 0, cap_n = 0;
  logic [7:0] cap_b [0:63];
  logic       cap_s [0:63];
  bit done = 0;

  assign bus_sda = sda_m & ~sda_pull;
  always #10 clk = ~clk;

  dispwr_i2c_rx uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda),
    .sda_pull_o(sda_pull), .pl_valid_o(pl_valid),
    .pl_byte_o(pl_byte), .pl_is_data_o(pl_is_data)
  );

  always @(negedge clk) begin
    if (pl_valid && cap_n < 64) begin
      cap_b[cap_n] = pl_byte;
      cap_s[cap_n] = pl_is_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_clk(HALF);
    scl = 1'b1;   wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl = 1'b0;   wait_clk(HALF);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_clk(HALF);
    scl = 1'b1;   wait_clk(HALF);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  // sends one byte, returns ack seen; checks release after the ninth clock (R10)
  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(HALF);
      scl = 1'b1;   wait_clk(HALF);
      scl = 1'b0;
    end
    sda_m = 1'b1; wait_clk(HALF);
    scl = 1'b1;   wait_clk(HALF/2);
    ack = (bus_sda == 1'b0);
    wait_clk(HALF - HALF/2);
    scl = 1'b0;   wait_clk(6);
    chk(!ack || !sda_pull, "R10 pull released after ack", sda_pull, 0);
  endtask

  task automatic expect_pl(input int idx, input logic [7:0] b, input logic s, input string req);
    chk(cap_b[idx] == b, req, cap_b[idx], b);
    chk(cap_s[idx] == s, "R8 select flag", cap_s[idx], s);
  endtask

  initial begin
    bit a;
    int base;
    wait_clk(3);
    chk(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    chk(pl_valid == 1'b0, "R1 reset valid", pl_valid, 0);
    rst = 1'b0;
    wait_clk(5);

    // table walk: one control/data pair per transfer
    for (int v = 0; v < NV; v++) begin
      base = cap_n;
      bus_start;
      wbyte(8'h7C, a); chk(a, "R2 address ack", a, 1);
      wbyte(VECS[v][15:8], a); chk(a, "R5 control ack", a, 1);
      wbyte(VECS[v][7:0], a);  chk(a, "R5 data ack", a, 1);
      bus_stop;
      chk(cap_n == base + 1, "R6 one payload per pair", cap_n - base, 1);
      expect_pl(base, VECS[v][7:0], VECS[v][14], "R8 payload value");
    end

    // R7: continuation clear, data stream with select 1
    base = cap_n;
    bus_start;
    wbyte(8'h7C, a);
    wbyte(8'h40, a);
    for (int k = 0; k < 4; k++) begin
      wbyte(8'h30 + 8'(k), a); chk(a, "R5 stream ack", a, 1);
    end
    bus_stop;
    chk(cap_n == base + 4, "R7 stream count", cap_n - base, 4);
    for (int k = 0; k < 4; k++) expect_pl(base + k, 8'h30 + 8'(k), 1'b1, "R7 stream byte");

    // R6: chained control bytes then switch to stream
    base = cap_n;
    bus_start;
    wbyte(8'h7C, a);
    wbyte(8'hC0, a); wbyte(8'h41, a);
    wbyte(8'h80, a); wbyte(8'h01, a);
    wbyte(8'h40, a); wbyte(8'h42, a); wbyte(8'h43, a);
    bus_stop;
    chk(cap_n == base + 4, "R6 chained count", cap_n - base, 4);
    expect_pl(base,     8'h41, 1'b1, "R6 chained first");
    expect_pl(base + 1, 8'h01, 1'b0, "R6 chained second");
    expect_pl(base + 2, 8'h42, 1'b1, "R7 after clear Co");
    expect_pl(base + 3, 8'h43, 1'b1, "R7 after clear Co");

    // R3: foreign address
    base = cap_n;
    bus_start;
    wbyte(8'h7E, a); chk(!a, "R3 no ack on mismatch", a, 0);
    wbyte(8'h40, a); chk(!a, "R3 following byte ignored", a, 0);
    wbyte(8'h55, a); chk(!a, "R3 following byte ignored", a, 0);
    bus_stop;
    chk(cap_n == base, "R3 no payload", cap_n - base, 0);

    // R4: read request
    base = cap_n;
    bus_start;
    wbyte(8'h7D, a); chk(!a, "R4 no ack on read", a, 0);
    wbyte(8'h00, a); chk(!a, "R4 byte after read ignored", a, 0);
    bus_stop;
    chk(cap_n == base, "R4 no payload", cap_n - base, 0);

    // R9: repeated start restarts at address phase
    base = cap_n;
    bus_start;
    wbyte(8'h7C, a);
    wbyte(8'h00, a); wbyte(8'h11, a);
    bus_start;
    wbyte(8'h7C, a); chk(a, "R9 address after repeated start", a, 1);
    wbyte(8'h40, a); wbyte(8'h22, a);
    bus_stop;
    chk(cap_n == base + 2, "R9 count", cap_n - base, 2);
    expect_pl(base,     8'h11, 1'b0, "R9 before restart");
    expect_pl(base + 1, 8'h22, 1'b1, "R9 after restart");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule